// File: doc/BRIEF.md
# Flash Status Register Protection Controller

This block owns the status byte and the write-protection decisions of a small serial NOR flash. An upstream SPI front end hands it one decoded instruction strobe per cycle (write enable, write disable, status read, status write with a data byte, page program, sector erase, block erase, chip erase and suspend), together with the write-protect pin, an OTP-mode flag and the target address of the instruction. The block answers each instruction by accepting it, dropping it, or ignoring it. An accepted operation raises the busy bit for a per-operation number of cycles.

The protection state is held in ordinary registers with reset defaults: a three-bit protection level, a top/bottom select, a status-guard bit and a one-time lock used in OTP mode. A program or erase whose sector range overlaps the protected region is dropped. A status write is refused while the guard bit is set and the write-protect pin is low. In OTP mode every program or erase targets the security sector, which the lock bit closes permanently. The array, the shifter and the real non-volatile storage are outside this block. It assumes at most one instruction strobe per cycle. If several arrive together, the order is status write, program, sector erase, block erase, chip erase, write enable, write disable.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte reads 0x00. Its layout is: bit 0 busy, bit 1 write-enable latch, bits 4:2 protection level, bit 5 bottom select, bit 6 reserved (always 0), bit 7 guard bit (lock bit while OTP mode is 1).
- R2: Write enable sets bit 1 and write disable clears it. Any status write, program or erase seen while idle clears bit 1, whether it is accepted or dropped.
- R3: A status write, program or erase issued while idle with bit 1 at 0 is dropped: op_drop pulses for one cycle and bit 0 stays 0.
- R4: An accepted operation pulses op_go in the cycle after the strobe and holds bit 0 at 1 for exactly its configured cycle count (defaults: status write 3, program 4, sector erase 6, block erase 9, chip erase 14).
- R5: While bit 0 is 1, every instruction except status read and suspend is ignored. This includes an instruction that arrives in the final busy cycle. The same instruction is accepted in the first idle cycle.
- R6: Outside OTP mode, an accepted status write copies data bits 7, 5 and 4:2 into the same status positions. Data bits 6, 1 and 0 have no effect.
- R7: With bottom select 0, protection level N (1..6) protects the highest 2^(N-1) of 64 sectors and level 7 protects all of them. The sector is address bits 15:10 and a block spans 4 aligned sectors. A program, sector erase, block erase or chip erase whose range overlaps the region is dropped.
- R8: With bottom select 1, the same region sizes are measured from sector 0 upward.
- R9: When bit 7 is 1 and wr_prot_n is 0, a status write is dropped and bits 7 and 5:2 keep their values. With wr_prot_n at 1 the same write is accepted.
- R10: Each suspend strobe during a busy program or erase toggles a hold that freezes the busy count, which stretches the busy time by the number of held cycles. Suspend during a busy status write has no effect.
- R11: In OTP mode, program and erase ignore the protection level. They are accepted while the lock bit is 0 and dropped once it is 1.
- R12: In OTP mode an accepted status write ignores its data and sets the lock bit. Bit 7 then reads 1 in OTP mode. A later status write in OTP mode is dropped, and the lock bit is never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Write-enable instruction strobe |
| cmd_wr_dis | input | 1 | Write-disable instruction strobe |
| cmd_rd_stat | input | 1 | Status-read instruction strobe |
| cmd_wr_stat | input | 1 | Status-write instruction strobe |
| wr_data | input | 8 | Data byte of the status write |
| cmd_prog | input | 1 | Page-program strobe |
| cmd_sect_erase | input | 1 | Sector-erase strobe |
| cmd_blk_erase | input | 1 | Block-erase strobe |
| cmd_chip_erase | input | 1 | Chip-erase strobe |
| cmd_suspend | input | 1 | Suspend strobe |
| wr_prot_n | input | 1 | Write-protect pin, active low |
| otp_mode | input | 1 | OTP mode select |
| tgt_addr | input | ADDR_W | Target byte address |
| status | output | 8 | Status byte |
| op_go | output | 1 | One-cycle pulse: operation accepted |
| op_drop | output | 1 | One-cycle pulse: operation dropped |

## Verification
Two things can fall in the same cycle: the busy counter reaching its last count, and the decode of a new instruction. The bench places a write enable exactly on the edge where busy falls and expects it to be ignored, then repeats it one cycle later and expects it to be taken. A second overlap is a suspend strobe arriving while the counter is still running. The total busy length after two toggles is compared with the configured count plus the held cycles. A behavioural reference model follows the status byte and both pulses on every clock, so any one-cycle slip at these boundaries shows as a mismatch.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_SREG  = 3'd1,
      OP_PROG  = 3'd2,
      OP_SECT  = 3'd3,
      OP_BLK   = 3'd4,
      OP_CHIP  = 3'd5
   } fsr_op_e;

   localparam int SB_BUSY = 0;
   localparam int SB_WEN  = 1;
   localparam int SB_LVL  = 2;
   localparam int SB_BOT  = 5;
   localparam int SB_RSV  = 6;
   localparam int SB_GRD  = 7;
endpackage

// File: rtl/fsr_region_check.sv
module fsr_region_check
   import fsr_pkg::*;
#(
   parameter int SECT_LOG2 = 6,
   parameter int BLK_LOG2  = 2
) (
   input  fsr_op_e              op,
   input  logic [SECT_LOG2-1:0] sect,
   input  logic [2:0]           level,
   input  logic                 from_bottom,
   output logic                 hit
);
   localparam int NSECT = 1 << SECT_LOG2;
   localparam int SW    = SECT_LOG2 + 1;
   localparam logic [SECT_LOG2-1:0] BLK_MASK = SECT_LOG2'((1 << BLK_LOG2) - 1);

   logic [SECT_LOG2-1:0] lo_s, hi_s;
   logic [SW-1:0]        span;

   // range of sectors touched by the operation
   always_comb begin
      case (op)
         OP_BLK: begin
            lo_s = sect & ~BLK_MASK;
            hi_s = sect | BLK_MASK;
         end
         OP_CHIP: begin
            lo_s = '0;
            hi_s = '1;
         end
         default: begin
            lo_s = sect;
            hi_s = sect;
         end
      endcase
   end

   // size of the protected region in sectors
   always_comb begin
      if (level == 3'd0)
         span = '0;
      else if (level == 3'd7)
         span = SW'(NSECT);
      else
         span = SW'(NSECT) >> (3'd7 - level);
   end

   always_comb begin
      if (span == '0)
         hit = 1'b0;
      else if (from_bottom)
         hit = ({1'b0, lo_s} < span);
      else
         hit = ({1'b0, hi_s} >= (SW'(NSECT) - span));
   end
endmodule

// File: rtl/fsr_busy_timer.sv
module fsr_busy_timer #(
   parameter int CNT_W      = 4,
   parameter bit SUSPEND_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             may_hold,
   input  logic             hold_req,
   output logic             busy
);
   logic [CNT_W-1:0] cnt_q;
   logic             hold_q;
   logic             toggle;
   logic             last;

   generate
      if (SUSPEND_EN) begin : g_susp
         assign toggle = hold_req & may_hold;
      end else begin : g_nosusp
         logic unused_hold;
         assign unused_hold = hold_req ^ may_hold;
         assign toggle      = 1'b0;
      end
   endgenerate

   assign last = busy && !hold_q && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt_q  <= '0;
         hold_q <= 1'b0;
      end else if (load) begin
         busy   <= 1'b1;
         cnt_q  <= load_val;
         hold_q <= 1'b0;
      end else if (busy) begin
         if (!hold_q) begin
            if (last) busy  <= 1'b0;
            else      cnt_q <= cnt_q - CNT_W'(1);
         end
         hold_q <= last ? 1'b0 : (hold_q ^ toggle);
      end
   end
endmodule

// File: rtl/flash_sr_guard.sv
module flash_sr_guard
   import fsr_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int SECT_LOG2  = 6,
   parameter int BLK_LOG2   = 2,
   parameter int T_SREG     = 3,
   parameter int T_PROG     = 4,
   parameter int T_SECT     = 6,
   parameter int T_BLK      = 9,
   parameter int T_CHIP     = 14,
   parameter bit SUSPEND_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_en,
   input  logic              cmd_wr_dis,
   input  logic              cmd_rd_stat,
   input  logic              cmd_wr_stat,
   input  logic [7:0]        wr_data,
   input  logic              cmd_prog,
   input  logic              cmd_sect_erase,
   input  logic              cmd_blk_erase,
   input  logic              cmd_chip_erase,
   input  logic              cmd_suspend,
   input  logic              wr_prot_n,
   input  logic              otp_mode,
   input  logic [ADDR_W-1:0] tgt_addr,
   output logic [7:0]        status,
   output logic              op_go,
   output logic              op_drop
);
   localparam int T_M1  = (T_SREG > T_PROG) ? T_SREG : T_PROG;
   localparam int T_M2  = (T_SECT > T_BLK)  ? T_SECT : T_BLK;
   localparam int T_M3  = (T_M1 > T_M2)     ? T_M1   : T_M2;
   localparam int T_MAX = (T_M3 > T_CHIP)   ? T_M3   : T_CHIP;
   localparam int CNT_W = $clog2(T_MAX + 1);
   localparam int LOW_W = ADDR_W - SECT_LOG2;

   generate
      if (SECT_LOG2 < 6) begin : g_bad_sect
         $error("SECT_LOG2 must be at least 6");
      end
      if (ADDR_W <= SECT_LOG2) begin : g_bad_addr
         $error("ADDR_W must exceed SECT_LOG2");
      end
      if (BLK_LOG2 < 1 || BLK_LOG2 >= SECT_LOG2) begin : g_bad_blk
         $error("BLK_LOG2 out of range");
      end
      if (T_SREG < 1 || T_PROG < 1 || T_SECT < 1 || T_BLK < 1 || T_CHIP < 1) begin : g_bad_t
         $error("operation durations must be at least 1");
      end
   endgenerate

   logic       wen_q;
   logic [2:0] prot_lvl_q;
   logic       prot_bottom_q;
   logic       sreg_guard_q;
   logic       otp_lock_q;
   logic       go_q, drop_q;
   fsr_op_e    kind_q;

   logic                 busy;
   fsr_op_e              op_req;
   logic                 region_hit;
   logic                 hw_locked;
   logic                 blocked;
   logic                 accept;
   logic                 refuse;
   logic [CNT_W-1:0]     dur;
   logic [SECT_LOG2-1:0] sect;
   logic                 unused_bits;

   assign sect        = tgt_addr[ADDR_W-1 -: SECT_LOG2];
   assign unused_bits = ^{tgt_addr[LOW_W-1:0], cmd_rd_stat};

   // single-request priority encode
   always_comb begin
      if      (cmd_wr_stat)    op_req = OP_SREG;
      else if (cmd_prog)       op_req = OP_PROG;
      else if (cmd_sect_erase) op_req = OP_SECT;
      else if (cmd_blk_erase)  op_req = OP_BLK;
      else if (cmd_chip_erase) op_req = OP_CHIP;
      else                     op_req = OP_NONE;
   end

   fsr_region_check #(
      .SECT_LOG2 (SECT_LOG2),
      .BLK_LOG2  (BLK_LOG2)
   ) u_region (
      .op          (op_req),
      .sect        (sect),
      .level       (prot_lvl_q),
      .from_bottom (prot_bottom_q),
      .hit         (region_hit)
   );

   assign hw_locked = sreg_guard_q & ~wr_prot_n;

   always_comb begin
      if (op_req == OP_SREG)
         blocked = hw_locked | (otp_mode & otp_lock_q);
      else if (otp_mode)
         blocked = otp_lock_q;
      else
         blocked = region_hit;
   end

   assign accept = !busy && (op_req != OP_NONE) && wen_q && !blocked;
   assign refuse = !busy && (op_req != OP_NONE) && !accept;

   always_comb begin
      case (op_req)
         OP_SREG: dur = CNT_W'(T_SREG);
         OP_PROG: dur = CNT_W'(T_PROG);
         OP_SECT: dur = CNT_W'(T_SECT);
         OP_BLK:  dur = CNT_W'(T_BLK);
         OP_CHIP: dur = CNT_W'(T_CHIP);
         default: dur = '0;
      endcase
   end

   fsr_busy_timer #(
      .CNT_W      (CNT_W),
      .SUSPEND_EN (SUSPEND_EN)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (dur),
      .may_hold (kind_q != OP_SREG),
      .hold_req (cmd_suspend),
      .busy     (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen_q         <= 1'b0;
         prot_lvl_q    <= 3'd0;
         prot_bottom_q <= 1'b0;
         sreg_guard_q  <= 1'b0;
         otp_lock_q    <= 1'b0;
         go_q          <= 1'b0;
         drop_q        <= 1'b0;
         kind_q        <= OP_NONE;
      end else begin
         go_q   <= accept;
         drop_q <= refuse;
         if (!busy) begin
            if (op_req != OP_NONE) wen_q <= 1'b0;
            else if (cmd_wr_en)    wen_q <= 1'b1;
            else if (cmd_wr_dis)   wen_q <= 1'b0;
         end
         if (accept) begin
            kind_q <= op_req;
            if (op_req == OP_SREG) begin
               if (otp_mode) begin
                  otp_lock_q <= 1'b1;
               end else begin
                  sreg_guard_q  <= wr_data[SB_GRD];
                  prot_bottom_q <= wr_data[SB_BOT];
                  prot_lvl_q    <= wr_data[SB_LVL +: 3];
               end
            end
         end
      end
   end

   always_comb begin
      status          = '0;
      status[SB_BUSY] = busy;
      status[SB_WEN]  = wen_q;
      status[SB_LVL +: 3] = prot_lvl_q;
      status[SB_BOT]  = prot_bottom_q;
      status[SB_RSV]  = 1'b0;
      status[SB_GRD]  = otp_mode ? otp_lock_q : sreg_guard_q;
   end

   assign op_go   = go_q;
   assign op_drop = drop_q;
endmodule

// File: rtl/flash_sr_guard_chk.sv
module flash_sr_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [7:0] status,
   input logic       op_go,
   input logic       op_drop,
   input logic       cmd_wr_stat,
   input logic       wr_prot_n,
   input logic       guard_q,
   input logic       lock_q
);
   // R4
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> op_go);

   // R2
   wen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_go |-> !status[1]);

   // R3
   drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_drop |-> (!status[0] && !op_go));

   // R5
   bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && $past(status[0])) |-> $stable(status[5:2]));

   // R9
   hw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_stat && !status[0] && guard_q && !wr_prot_n) |=> !op_go);

   // R12
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(lock_q));
endmodule

bind flash_sr_guard flash_sr_guard_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .status      (status),
   .op_go       (op_go),
   .op_drop     (op_drop),
   .cmd_wr_stat (cmd_wr_stat),
   .wr_prot_n   (wr_prot_n),
   .guard_q     (sreg_guard_q),
   .lock_q      (otp_lock_q)
);

// File: tb/flash_sr_guard_bench.sv
module flash_sr_guard_bench;
   localparam int TS = 3, TP = 4, TSE = 6, TB = 9, TC = 14;
   localparam int K_WEN = 0, K_WDIS = 1, K_RD = 2, K_WST = 3, K_PROG = 4,
                  K_SE = 5, K_BE = 6, K_CE = 7, K_SUSP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr_en = 0, cmd_wr_dis = 0, cmd_rd_stat = 0, cmd_wr_stat = 0;
   logic [7:0]  wr_data = 0;
   logic        cmd_prog = 0, cmd_sect_erase = 0, cmd_blk_erase = 0, cmd_chip_erase = 0;
   logic        cmd_suspend = 0;
   logic        wr_prot_n = 1'b1;
   logic        otp_mode = 1'b0;
   logic [15:0] tgt_addr = 0;
   logic [7:0]  status;
   logic        op_go, op_drop;

   int n_chk = 0, n_fail = 0, bcnt = 0;
   bit done = 0;

   always #4 clk = ~clk;

   flash_sr_guard #(.T_SREG(TS), .T_PROG(TP), .T_SECT(TSE), .T_BLK(TB), .T_CHIP(TC))
   u_flash_sr_guard (
      .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_dis(cmd_wr_dis),
      .cmd_rd_stat(cmd_rd_stat), .cmd_wr_stat(cmd_wr_stat), .wr_data(wr_data),
      .cmd_prog(cmd_prog), .cmd_sect_erase(cmd_sect_erase), .cmd_blk_erase(cmd_blk_erase),
      .cmd_chip_erase(cmd_chip_erase), .cmd_suspend(cmd_suspend), .wr_prot_n(wr_prot_n),
      .otp_mode(otp_mode), .tgt_addr(tgt_addr), .status(status), .op_go(op_go),
      .op_drop(op_drop));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model state
   int m_busy, m_wen, m_lvl, m_bot, m_grd, m_lock, m_cnt, m_hold, m_kind, m_go, m_drop;

   function automatic int m_status();
      return ((otp_mode ? m_lock : m_grd) << 7) | (m_bot << 5) | (m_lvl << 2)
             | (m_wen << 1) | m_busy;
   endfunction

   function automatic bit m_hit(input int kind, input int sect);
      int span, lo, hi;
      span = (m_lvl == 0) ? 0 : (m_lvl == 7) ? 64 : (1 << (m_lvl - 1));
      lo = sect; hi = sect;
      if (kind == 4) begin lo = (sect / 4) * 4; hi = lo + 3; end
      if (kind == 5) begin lo = 0; hi = 63; end
      if (span == 0) return 0;
      if (m_bot != 0) return lo < span;
      return hi >= 64 - span;
   endfunction

   function automatic int m_dur(input int kind);
      case (kind)
         1: return TS; 2: return TP; 3: return TSE; 4: return TB; default: return TC;
      endcase
   endfunction

   always @(posedge clk) begin
      int req; bit ok, fin;
      if (!rst_n) begin
         m_busy = 0; m_wen = 0; m_lvl = 0; m_bot = 0; m_grd = 0; m_lock = 0;
         m_cnt = 0; m_hold = 0; m_kind = 0; m_go = 0; m_drop = 0;
      end else begin
         m_go = 0; m_drop = 0; fin = 0;
         if (m_busy != 0) begin
            if (m_hold == 0) begin
               if (m_cnt == 1) begin m_busy = 0; fin = 1; end
               else m_cnt = m_cnt - 1;
            end
            if (fin) m_hold = 0;
            else if (cmd_suspend && m_kind != 1) m_hold = 1 - m_hold;
         end else begin
            req = cmd_wr_stat ? 1 : cmd_prog ? 2 : cmd_sect_erase ? 3 :
                  cmd_blk_erase ? 4 : cmd_chip_erase ? 5 : 0;
            if (req != 0) begin
               ok = (m_wen != 0);
               if (req == 1)
                  ok = ok && !(m_grd != 0 && !wr_prot_n) && !(otp_mode && m_lock != 0);
               else if (otp_mode)
                  ok = ok && (m_lock == 0);
               else
                  ok = ok && !m_hit(req, int'(tgt_addr[15:10]));
               m_wen = 0;
               if (ok) begin
                  m_busy = 1; m_cnt = m_dur(req); m_kind = req; m_hold = 0; m_go = 1;
                  if (req == 1) begin
                     if (otp_mode) m_lock = 1;
                     else begin
                        m_grd = int'(wr_data[7]); m_bot = int'(wr_data[5]);
                        m_lvl = int'(wr_data[4:2]);
                     end
                  end
               end else m_drop = 1;
            end else if (cmd_wr_en) m_wen = 1;
            else if (cmd_wr_dis) m_wen = 0;
         end
      end
      #2;
      if (rst_n && !done)
         chk(status == 8'(m_status()) && op_go == m_go[0] && op_drop == m_drop[0],
             "MODEL", {status, 6'd0, op_go, op_drop},
             {8'(m_status()), 6'd0, m_go[0], m_drop[0]});
   end

   always @(negedge clk) if (rst_n && status[0]) bcnt++;

   task automatic pulse(input int which, input int sect = 0, input int d = 0);
      tgt_addr = 16'(sect << 10);
      wr_data  = 8'(d);
      case (which)
         K_WEN:  cmd_wr_en = 1;     K_WDIS: cmd_wr_dis = 1;
         K_RD:   cmd_rd_stat = 1;   K_WST:  cmd_wr_stat = 1;
         K_PROG: cmd_prog = 1;      K_SE:   cmd_sect_erase = 1;
         K_BE:   cmd_blk_erase = 1; K_CE:   cmd_chip_erase = 1;
         default: cmd_suspend = 1;
      endcase
      @(negedge clk);
      {cmd_wr_en, cmd_wr_dis, cmd_rd_stat, cmd_wr_stat, cmd_prog, cmd_sect_erase,
       cmd_blk_erase, cmd_chip_erase, cmd_suspend} = '0;
   endtask

   task automatic wait_idle();
      while (status[0]) @(negedge clk);
   endtask

   task automatic sreg_write(input int d);
      pulse(K_WEN);
      pulse(K_WST, 0, d);
      wait_idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk(status == 8'h00, "R1 reset status", status, 8'h00);
      pulse(K_WEN);
      chk(status == 8'h02, "R2 write enable", status, 8'h02);
      pulse(K_WDIS);
      chk(status == 8'h00, "R2 write disable", status, 8'h00);
      pulse(K_PROG, 0);
      chk(op_drop && status == 8'h00, "R3 program without latch", {op_drop, status}, 9'h100);

      // R4 program timing, R5 collision at the last busy cycle
      pulse(K_WEN); bcnt = 0;
      pulse(K_PROG, 0);
      chk(op_go == 1, "R4 program accepted", op_go, 1);
      chk(status[1] == 0, "R2 latch cleared by program", status[1], 0);
      @(negedge clk); @(negedge clk);
      pulse(K_RD);
      pulse(K_WEN);
      chk(status == 8'h00, "R5 enable in last busy cycle ignored", status, 8'h00);
      chk(bcnt == TP, "R4 program busy length", bcnt, TP);
      pulse(K_WEN);
      chk(status == 8'h02, "R5 enable taken after busy", status, 8'h02);

      // R6 status write field mapping
      pulse(K_WST, 0, 8'h43);
      chk(op_go == 1, "R6 status write accepted", op_go, 1);
      wait_idle();
      chk(status == 8'h00, "R6 data bits 6,1,0 ignored", status, 8'h00);
      sreg_write(8'h0C);
      chk(status == 8'h0C, "R6 level 3 stored", status, 8'h0C);

      // R7 top protection
      pulse(K_WEN); pulse(K_PROG, 61);
      chk(op_drop && status == 8'h0C, "R7 program in top region", {op_drop, status}, 9'h10C);
      pulse(K_WEN); pulse(K_PROG, 59);
      chk(op_go == 1, "R7 program below region", op_go, 1);
      wait_idle();
      pulse(K_WEN); pulse(K_BE, 57);
      chk(op_go == 1, "R7 block clear of region", op_go, 1);
      wait_idle();
      pulse(K_WEN); pulse(K_BE, 60);
      chk(op_drop == 1, "R7 block overlapping region", op_drop, 1);
      pulse(K_WEN); pulse(K_CE);
      chk(op_drop == 1, "R7 chip erase with level set", op_drop, 1);

      // R8 bottom protection
      sreg_write(8'h2C);
      chk(status == 8'h2C, "R8 bottom select stored", status, 8'h2C);
      pulse(K_WEN); pulse(K_SE, 2);
      chk(op_drop == 1, "R8 sector in bottom region", op_drop, 1);
      pulse(K_WEN); pulse(K_SE, 63);
      chk(op_go == 1, "R8 top sector open", op_go, 1);
      wait_idle();

      // R7 full array, then chip erase timing
      sreg_write(8'h1C);
      pulse(K_WEN); pulse(K_PROG, 0);
      chk(op_drop == 1, "R7 level 7 protects all", op_drop, 1);
      sreg_write(8'h00);
      pulse(K_WEN); bcnt = 0; pulse(K_CE);
      wait_idle();
      chk(bcnt == TC, "R4 chip erase busy length", bcnt, TC);

      // R9 hardware protection
      sreg_write(8'h84);
      chk(status == 8'h84, "R9 guard bit stored", status, 8'h84);
      wr_prot_n = 0;
      pulse(K_WEN); pulse(K_WST, 0, 8'h00);
      chk(op_drop && status == 8'h84, "R9 write refused with pin low", {op_drop, status}, 9'h184);
      wr_prot_n = 1;
      sreg_write(8'h00);
      chk(status == 8'h00, "R9 write taken with pin high", status, 8'h00);

      // R10 suspend
      pulse(K_WEN); bcnt = 0; pulse(K_SE, 0);
      pulse(K_SUSP);
      repeat (3) @(negedge clk);
      pulse(K_SUSP);
      wait_idle();
      chk(bcnt == TSE + 4, "R10 suspend stretches erase", bcnt, TSE + 4);
      pulse(K_WEN); bcnt = 0; pulse(K_WST, 0, 8'h00);
      pulse(K_SUSP);
      wait_idle();
      chk(bcnt == TS, "R10 suspend ignored on status write", bcnt, TS);

      // R11 / R12 OTP lock
      otp_mode = 1; @(negedge clk);
      chk(status == 8'h00, "R12 lock clear in OTP", status, 8'h00);
      pulse(K_WEN); pulse(K_PROG, 63);
      chk(op_go == 1, "R11 open security sector", op_go, 1);
      wait_idle();
      sreg_write(8'h1C);
      chk(status == 8'h80, "R12 lock set, data ignored", status, 8'h80);
      pulse(K_WEN); pulse(K_PROG, 63);
      chk(op_drop == 1, "R11 locked security sector", op_drop, 1);
      pulse(K_WEN); pulse(K_WST, 0, 8'h00);
      chk(op_drop && status == 8'h80, "R12 second lock write refused", {op_drop, status}, 9'h180);
      otp_mode = 0; @(negedge clk);
      chk(status == 8'h00, "R12 guard view outside OTP", status, 8'h00);
      otp_mode = 1; @(negedge clk);
      chk(status == 8'h80, "R12 lock persists", status, 8'h80);

      repeat (2) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule